// File: doc/BRIEF.md
# Open-String Lockout and Feedback Selector

This block decides which of four LED strings are allowed to steer the feedback loop of a shared boost converter. An overvoltage detector watches a sampled current code from the overvoltage sense pin and applies current hysteresis to it. Each time that detector turns on, the block looks at every enabled string. Any string that is not in regulation at that moment is locked out of loop control. Strings that are in regulation again are released. The mask then holds its value until the next overvoltage event or a shutdown pulse. Short enable-low periods used for PWM dimming leave the mask untouched.

From the enabled strings that are not locked, a registered selector passes the one with the least headroom to the loop. If two strings tie, the lower index wins. If no string is eligible, the block raises a flag and drives the feedback value to full scale, so the loop never pushes the output voltage higher. The block has no output that disables a current sink. Locked strings keep sinking their set current. Only feedback steering is affected.

Top module: `led_string_lockout`

## Requirements
- R1: With the detector off, it turns on only when the 8-bit unsigned current code (1 µA per LSB) is strictly greater than OVP_ON (default 200). A code equal to OVP_ON has no effect.
- R2: With the detector on, it turns off only when the code is strictly below OVP_OFF (default 165). Codes at or above OVP_OFF keep it on, and no new lockout event occurs while it stays on.
- R3: Suppose the detector turns on at clock edge N. At edge N+1, lock_mask is loaded with ch_en AND NOT in_reg, using the values present at that edge. Bit i of each vector belongs to string i. Strings that are now in regulation are therefore released.
- R4: Between events, lock_mask holds its value no matter how in_reg, ch_en or headroom change.
- R5: A high shutdown input clears lock_mask at the next edge. It takes priority over an event at the same edge.
- R6: One clock after its inputs, fb_idx and fb_val show the string with the smallest headroom among those with ch_en set and lock_mask clear. Ties go to the lowest index. String i's headroom is headroom[i*8 +: 8].
- R7: When no string is eligible, all_locked is 1, fb_val is all ones and fb_idx is 0, one clock after the condition.
- R8: During reset, lock_mask is 0, all_locked is 1, fb_val is all ones and fb_idx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ovp_code | input | 8 | Sampled overvoltage-pin current, 1 µA per LSB |
| in_reg | input | 4 | Per-string in-regulation flags |
| ch_en | input | 4 | Per-string channel enables |
| headroom | input | 32 | Packed per-string headroom codes, 8 bits each |
| shutdown | input | 1 | Shutdown pulse that clears the lockout mask |
| lock_mask | output | 4 | Strings excluded from loop control |
| fb_idx | output | 2 | Index of the selected feedback string |
| fb_val | output | 8 | Headroom of the selected string, or full scale |
| all_locked | output | 1 | No string is eligible for feedback |

## Verification
Four properties are checked on every cycle:
- the two hysteresis bands of the detector;
- the mask holding between events;
- the clear after shutdown;
- the agreement between all_locked and eligibility, with fb_val at full scale whenever all_locked is set.

The bench scenarios cover the rest. These are the exact threshold boundaries seen at the mask, re-evaluation on a second event releasing strings, shutdown colliding with an event, disabled channels excluded from both lockout and selection, and tie-breaking on equal headroom. A random phase with codes clustered around both thresholds is compared cycle by cycle against a model built from the requirements.

// File: rtl/led_string_lockout.sv
module led_string_lockout #(
  parameter int NSTR    = 4,
  parameter int CW      = 8,
  parameter int HW      = 8,
  parameter int OVP_ON  = 200,
  parameter int OVP_OFF = 165
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CW-1:0]      ovp_code,
  input  logic [NSTR-1:0]    in_reg,
  input  logic [NSTR-1:0]    ch_en,
  input  logic [NSTR*HW-1:0] headroom,
  input  logic               shutdown,
  output logic [NSTR-1:0]    lock_mask,
  output logic [$clog2(NSTR)-1:0] fb_idx,
  output logic [HW-1:0]      fb_val,
  output logic               all_locked
);
  localparam int IW = $clog2(NSTR);

  logic ovp_q, ovp_d, ovp_nxt, ovp_rise;
  logic [NSTR-1:0] elig;
  logic [IW-1:0] best_i;
  logic [HW-1:0] best_v;
  logic found;

  assign ovp_nxt  = ovp_q ? (ovp_code >= CW'(OVP_OFF)) : (ovp_code > CW'(OVP_ON));
  assign ovp_rise = ovp_q & ~ovp_d;
  assign elig     = ch_en & ~lock_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovp_q <= 1'b0;
      ovp_d <= 1'b0;
    end else begin
      ovp_q <= ovp_nxt;
      ovp_d <= ovp_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lock_mask <= '0;
    else if (shutdown) lock_mask <= '0;
    else if (ovp_rise) lock_mask <= ch_en & ~in_reg;
  end

  always_comb begin
    best_v = '1;
    best_i = '0;
    found  = 1'b0;
    for (int i = 0; i < NSTR; i++) begin
      if (elig[i] && (!found || headroom[i*HW +: HW] < best_v)) begin
        best_v = headroom[i*HW +: HW];
        best_i = IW'(i);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_idx     <= '0;
      fb_val     <= '1;
      all_locked <= 1'b1;
    end else begin
      fb_idx     <= best_i;
      fb_val     <= best_v;
      all_locked <= ~found;
    end
  end

  AST_ON_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovp_q && ovp_code <= CW'(OVP_ON)) |=> !ovp_q); // R1
  AST_OFF_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_q && ovp_code >= CW'(OVP_OFF)) |=> ovp_q); // R2
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovp_rise && !shutdown) |=> $stable(lock_mask)); // R4
  AST_SD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> (lock_mask == '0)); // R5
  AST_NONE_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (all_locked == ($past(elig) == '0))); // R7
  AST_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    all_locked |-> (fb_val == '1 && fb_idx == '0)); // R7
endmodule

// File: tb/led_string_lockout_tb.sv
module led_string_lockout_tb;
  logic clk = 0, rst_n = 0;
  logic [7:0]  ovp_code = 0;
  logic [3:0]  in_reg = 0, ch_en = 0;
  logic [31:0] headroom = 0;
  logic        shutdown = 0;
  logic [3:0]  lock_mask;
  logic [1:0]  fb_idx;
  logic [7:0]  fb_val;
  logic        all_locked;
  int checks = 0, errors = 0;
  bit done = 0;

  // bench-side expectation state
  bit m_on, m_on_d;
  logic [3:0] m_mask;

  always #5 clk = ~clk;

  led_string_lockout u_dut (.clk, .rst_n, .ovp_code, .in_reg, .ch_en, .headroom,
    .shutdown, .lock_mask, .fb_idx, .fb_val, .all_locked);

  function automatic logic [7:0] hr(input logic [31:0] h, input int i);
    return h[i*8 +: 8];
  endfunction

  function automatic logic [1:0] exp_idx(input logic [3:0] el, input logic [31:0] h);
    logic [1:0] bi = 0; logic [7:0] bv = 8'hFF; bit f = 0;
    for (int i = 0; i < 4; i++)
      if (el[i] && (!f || hr(h, i) < bv)) begin bv = hr(h, i); bi = 2'(i); f = 1; end
    return bi;
  endfunction

  function automatic logic [7:0] exp_val(input logic [3:0] el, input logic [31:0] h);
    logic [7:0] bv = 8'hFF; bit f = 0;
    for (int i = 0; i < 4; i++)
      if (el[i] && (!f || hr(h, i) < bv)) begin bv = hr(h, i); f = 1; end
    return bv;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one clock: inputs already driven; model advances with the edge
  task automatic step();
    logic [3:0] el;
    el = ch_en & ~m_mask;
    @(posedge clk);
    if (shutdown) m_mask = 0;
    else if (m_on && !m_on_d) m_mask = ch_en & ~in_reg;
    m_on_d = m_on;
    m_on = m_on ? (ovp_code >= 165) : (ovp_code > 200);
    @(negedge clk);
    if (0) el = el;
  endtask

  task automatic stepn(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] el_prev;
    void'($urandom(32'd2718));
    m_on = 0; m_on_d = 0; m_mask = 0;
    #22;
    chk("R8 mask", lock_mask, 4'h0);
    chk("R8 all_locked", all_locked, 1);
    chk("R8 fb_val", fb_val, 8'hFF);
    chk("R8 fb_idx", fb_idx, 0);
    @(negedge clk); rst_n = 1;

    ch_en = 4'hF; in_reg = 4'hF; headroom = {8'd40, 8'd30, 8'd20, 8'd30};
    stepn(2);
    chk("R6 min idx", fb_idx, 1);
    chk("R6 min val", fb_val, 20);
    chk("R6 not locked", all_locked, 0);
    headroom = {8'd40, 8'd30, 8'd20, 8'd20};
    step();
    chk("R6 tie lowest", fb_idx, 0);

    ovp_code = 200; in_reg = 4'b1010;
    stepn(3);
    chk("R1 equal no event", lock_mask, 4'h0);
    ovp_code = 201;
    step();
    chk("R3 not before N+1", lock_mask, 4'h0);
    step();
    chk("R3 event mask", lock_mask, 4'b0101);
    step();
    chk("R6 eligible idx", fb_idx, 1);
    chk("R6 eligible val", fb_val, 20);

    ovp_code = 165; in_reg = 4'b0000;
    stepn(3);
    chk("R2 hold at 165", lock_mask, 4'b0101);
    ovp_code = 255;
    stepn(3);
    chk("R2 no retrigger", lock_mask, 4'b0101);
    chk("R4 mask held", lock_mask, 4'b0101);

    ovp_code = 164; step();
    ovp_code = 230; stepn(2);
    chk("R3 reevaluate", lock_mask, 4'hF);
    step();
    chk("R7 all_locked", all_locked, 1);
    chk("R7 full scale", fb_val, 8'hFF);
    chk("R7 idx zero", fb_idx, 0);

    shutdown = 1; step(); shutdown = 0;
    chk("R5 clear", lock_mask, 4'h0);
    stepn(2);
    chk("R5 stays clear", lock_mask, 4'h0);

    ovp_code = 100; ch_en = 4'b0011; step();
    ovp_code = 250; stepn(2);
    chk("R3 disabled not locked", lock_mask, 4'b0011);
    step();
    chk("R7 none enabled free", all_locked, 1);
    ch_en = 4'hF; step();
    chk("R6 disabled skip idx", fb_idx, 2);
    chk("R6 disabled skip val", fb_val, 30);

    ovp_code = 100; step();
    ovp_code = 250; in_reg = 4'b0000; step();
    shutdown = 1; step(); shutdown = 0;
    chk("R5 beats event", lock_mask, 4'h0);

    for (int c = 0; c < 3000; c++) begin
      int r = $urandom_range(0, 9);
      ovp_code = (r < 4) ? 8'(163 + $urandom_range(0, 4)) :
                 (r < 8) ? 8'(198 + $urandom_range(0, 4)) : 8'($urandom);
      if ($urandom_range(0, 3) == 0) in_reg = 4'($urandom);
      if ($urandom_range(0, 7) == 0) ch_en = 4'($urandom);
      if ($urandom_range(0, 2) == 0) headroom = $urandom;
      shutdown = ($urandom_range(0, 40) == 0);
      el_prev = ch_en & ~m_mask;
      step();
      chk("R3 R4 R5 random mask", lock_mask, m_mask);
      chk("R6 random idx", fb_idx, exp_idx(el_prev, headroom));
      chk("R6 random val", fb_val, exp_val(el_prev, headroom));
      chk("R7 random flag", all_locked, el_prev == 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule